// File: doc/BRIEF.md
# Pipelined Fixed-Complexity List Sphere Detector

This block finds soft bit decisions for a two-antenna spatial-multiplexing link. The link is written in real-valued form as four real layers, each carrying one 4-PAM symbol, so one vector holds eight bits. Every clock cycle the block can take one received vector that has already been rotated by the channel's QR decomposition, together with the ten entries of the upper-triangular matrix. It returns one set of eight log-likelihood ratios per accepted vector, at a fixed latency.

The search does not adapt to the data. The node count of each layer is fixed when the design is built. The two top layers are searched over every symbol, which gives sixteen paths. The two lower layers extend each path by one child only: the constellation point nearest to the value left after interference cancellation. Each tree layer has its own register stage and data moves one way, from root to leaves. A last stage turns the sixteen path metrics into per-bit soft values. A valid flag moves along with the data, so gaps in the input stream reach the output unchanged.

The block is meant to sit between a QR preprocessing unit and a channel decoder. Several copies can run side by side when one code block spans many vectors.

Top module: `lfsd_detector`

## Requirements
- R1: `outValid` is `inValid` delayed by exactly 5 clock cycles. A gap in the input produces a gap in the output in the same position.
- R2: A new vector is accepted on every cycle that `inValid` is high, including back-to-back cycles. Each accepted vector produces its own result.
- R3: While `rst` is high, and after it is released until the first result arrives, `outValid` is 0 and `outLlr` is all zeros.
- R4: Layers 3 and 2 are searched exhaustively. The list holds one path for each of the 16 (s3, s2) pairs, so the bits of these two symbols always have both hypotheses.
- R5: Layers 1 and 0 extend each path with the 4-PAM point nearest to z/r_ii. Here z is the received value minus the contributions of the symbols already chosen. When two points are equally near, the larger one wins. Diagonal entries r_ii are positive.
- R6: A path metric is the sum over layers of (y_i − Σ_{j≥i} r_ij·s_j)². Each squared term saturates at 2^METRIC_W − 1, and so does each partial sum (65535 by default).
- R7: For each bit, the soft value is (smallest metric among paths with the bit equal to 1) − (smallest metric among paths with the bit equal to 0). The result is clipped to ±(2^(LLR_W−1) − 1), which is ±2047 by default. A positive value favours 0.
- R8: If no path in the list has the bit equal to 1, the soft value is +(2^(LLR_W−1) − 1). If no path has the bit equal to 0, it is the negative of that value.
- R9: Symbol index i ∈ {0,1,2,3} stands for the amplitude 2i − 3. Its Gray label is 00, 01, 11, 10 in that order. The soft value of layer k's label LSB is at `outLlr[(2k)*LLR_W +: LLR_W]`, and the label MSB is at slot 2k+1. `rxVec` holds y_k at `[k*IN_W +: IN_W]`. `rMat` holds r_ij (i ≤ j) in row-major order of the upper triangle: r00, r01, r02, r03, r11, r12, r13, r22, r23, r33.
- R10: On any cycle where `outValid` is low, `outLlr` keeps the value it had on the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Qualifies `rxVec` and `rMat` this cycle |
| rxVec | input | 4*IN_W | Rotated received vector, four signed samples |
| rMat | input | 10*IN_W | Upper-triangular channel entries, signed, row-major |
| outValid | output | 1 | Qualifies `outLlr` |
| outLlr | output | 8*LLR_W | Eight signed soft values, two per layer |

## Verification
On every cycle, the assertions check the five-cycle valid delay, the clean state after reset, that soft values hold during gaps, and that no soft value ever takes the most negative code. Whether the values themselves are right can only be shown by the bench scenarios, which compare each result with an exhaustive per-path reference model. The directed vectors cover a noiseless vector whose signs must reproduce the sent Gray bits, exact slicer ties, metrics driven into saturation, and lower-layer bits whose opposite hypothesis is absent from the list.

// File: rtl/lfsd_pkg.sv
package lfsd_pkg;
  localparam int NUM_LAYERS = 4;
  localparam int SYM_BITS   = 2;
  localparam int NUM_PATHS  = 16;
  localparam int NUM_BITS   = NUM_LAYERS * SYM_BITS;
  localparam int NUM_TRI    = NUM_LAYERS * (NUM_LAYERS + 1) / 2;
  localparam int NUM_STAGES = 5;

  typedef logic [SYM_BITS-1:0] symIdx_t;

  // Per-stage capture enables handed from control to the datapath
  typedef struct packed {
    logic [NUM_STAGES-2:0] treeLoad;
    logic                  llrLoad;
  } strobe_t;

  // Position of r(i,j), i <= j, in the row-major upper triangle
  function automatic int triIdx(int i, int j);
    return i * NUM_LAYERS - (i * (i - 1)) / 2 + (j - i);
  endfunction

  // Binary-reflected label of a symbol index
  function automatic symIdx_t grayOf(symIdx_t i);
    return i ^ {1'b0, i[SYM_BITS-1]};
  endfunction
endpackage

// File: rtl/lfsd_ctrl.sv
module lfsd_ctrl
  import lfsd_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    inValid,
  output strobe_t strobe,
  output logic    outValid
);
  logic [NUM_STAGES-1:0] stageVld;

  always_ff @(posedge clk) begin
    if (rst) stageVld <= '0;
    else     stageVld <= {stageVld[NUM_STAGES-2:0], inValid};
  end

  // Stage k captures when the data feeding it is valid
  assign strobe.treeLoad = {stageVld[NUM_STAGES-3:0], inValid};
  assign strobe.llrLoad  = stageVld[NUM_STAGES-2];
  assign outValid        = stageVld[NUM_STAGES-1];
endmodule

// File: rtl/lfsd_tree.sv
module lfsd_tree
  import lfsd_pkg::*;
#(
  parameter int IN_W     = 10,
  parameter int METRIC_W = 16
) (
  input  logic                            clk,
  input  logic [NUM_STAGES-2:0]           load,
  input  logic [NUM_LAYERS*IN_W-1:0]      rxVec,
  input  logic [NUM_TRI*IN_W-1:0]         rMat,
  output logic [NUM_PATHS*METRIC_W-1:0]   pathMetric,
  output logic [NUM_PATHS*NUM_BITS-1:0]   pathSym
);
  localparam int ZW = IN_W + 5;
  localparam int T03 = triIdx(0, 3);
  localparam int T11 = triIdx(1, 1);
  localparam int T12 = triIdx(1, 2);
  localparam int T13 = triIdx(1, 3);
  localparam int T22 = triIdx(2, 2);
  localparam int T23 = triIdx(2, 3);
  localparam int T33 = triIdx(3, 3);
  localparam int NUM_SYM = 1 << SYM_BITS;
  localparam logic [2*ZW-1:0] SQ_LIMIT = {{(2*ZW-METRIC_W){1'b0}}, {METRIC_W{1'b1}}};

  typedef logic signed [IN_W-1:0] sample_t;
  typedef logic signed [ZW-1:0]   wide_t;
  typedef logic [METRIC_W-1:0]    metric_t;

  // r * amplitude(i), amplitude = 2i - 3, without a multiplier
  function automatic wide_t symTerm(sample_t r, symIdx_t i);
    wide_t rw;
    rw = wide_t'(r);
    case (i)
      2'd0:    return -(rw + rw + rw);
      2'd1:    return -rw;
      2'd2:    return rw;
      default: return rw + rw + rw;
    endcase
  endfunction

  // Nearest amplitude to z/r for r > 0; ties go to the larger point
  function automatic symIdx_t slice(wide_t z, sample_t r);
    wide_t twoR;
    twoR = wide_t'(r) + wide_t'(r);
    if (z >= twoR)       return 2'd3;
    else if (z >= 0)     return 2'd2;
    else if (z >= -twoR) return 2'd1;
    else                 return 2'd0;
  endfunction

  function automatic metric_t satSq(wide_t z);
    logic signed [2*ZW-1:0] zx;
    logic [2*ZW-1:0]        sq;
    zx = (2*ZW)'(z);
    sq = $unsigned(zx * zx);
    return (sq > SQ_LIMIT) ? '1 : sq[METRIC_W-1:0];
  endfunction

  function automatic metric_t satAdd(metric_t a, metric_t b);
    logic [METRIC_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[METRIC_W] ? '1 : s[METRIC_W-1:0];
  endfunction

  sample_t yIn [NUM_LAYERS];
  sample_t rIn [NUM_TRI];

  // Stage 1 (layer 3) state
  sample_t yS1 [NUM_LAYERS-1];
  sample_t rS1 [T33];
  metric_t pedTop     [NUM_SYM];
  metric_t pedTopNext [NUM_SYM];
  // Stage 2 (layer 2) state
  sample_t yS2 [NUM_LAYERS-2];
  sample_t rS2 [T22];
  metric_t m2     [NUM_PATHS];
  metric_t m2Next [NUM_PATHS];
  // Stage 3 (layer 1) state
  sample_t yS3;
  sample_t rS3 [T11];
  metric_t m3     [NUM_PATHS];
  metric_t m3Next [NUM_PATHS];
  symIdx_t s1S3   [NUM_PATHS];
  symIdx_t s1Next [NUM_PATHS];
  // Stage 4 (layer 0) state
  metric_t m4     [NUM_PATHS];
  metric_t m4Next [NUM_PATHS];
  symIdx_t s1S4   [NUM_PATHS];
  symIdx_t s0S4   [NUM_PATHS];
  symIdx_t s0Next [NUM_PATHS];

  for (genvar i = 0; i < NUM_LAYERS; i++) begin : g_yUnpack
    assign yIn[i] = rxVec[i*IN_W +: IN_W];
  end
  for (genvar i = 0; i < NUM_TRI; i++) begin : g_rUnpack
    assign rIn[i] = rMat[i*IN_W +: IN_W];
  end

  // Root layer: one partial distance per candidate symbol
  for (genvar c = 0; c < NUM_SYM; c++) begin : g_root
    assign pedTopNext[c] = satSq(wide_t'(yIn[NUM_LAYERS-1]) - symTerm(rIn[T33], symIdx_t'(c)));
  end

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    localparam symIdx_t C3 = symIdx_t'(p >> SYM_BITS);
    localparam symIdx_t C2 = symIdx_t'(p % NUM_SYM);
    wide_t   z2, z1, e1, z0, e0;
    symIdx_t s1, s0;

    // Layer 2: exhaustive child under each root symbol
    assign z2        = wide_t'(yS1[2]) - symTerm(rS1[T22], C2) - symTerm(rS1[T23], C3);
    assign m2Next[p] = satAdd(pedTop[C3], satSq(z2));

    // Layer 1: single nearest child
    assign z1        = wide_t'(yS2[1]) - symTerm(rS2[T12], C2) - symTerm(rS2[T13], C3);
    assign s1        = slice(z1, rS2[T11]);
    assign e1        = z1 - symTerm(rS2[T11], s1);
    assign m3Next[p] = satAdd(m2[p], satSq(e1));
    assign s1Next[p] = s1;

    // Layer 0: single nearest child
    assign z0        = wide_t'(yS3) - symTerm(rS3[1], s1S3[p]) - symTerm(rS3[2], C2)
                       - symTerm(rS3[T03], C3);
    assign s0        = slice(z0, rS3[0]);
    assign e0        = z0 - symTerm(rS3[0], s0);
    assign m4Next[p] = satAdd(m3[p], satSq(e0));
    assign s0Next[p] = s0;

    assign pathMetric[p*METRIC_W +: METRIC_W] = m4[p];
    assign pathSym[p*NUM_BITS +: NUM_BITS]    = {C3, C2, s1S4[p], s0S4[p]};
  end

  always_ff @(posedge clk) begin
    if (load[0]) begin
      for (int k = 0; k < NUM_LAYERS - 1; k++) yS1[k] <= yIn[k];
      for (int k = 0; k < T33; k++) rS1[k] <= rIn[k];
      pedTop <= pedTopNext;
    end
    if (load[1]) begin
      for (int k = 0; k < NUM_LAYERS - 2; k++) yS2[k] <= yS1[k];
      for (int k = 0; k < T22; k++) rS2[k] <= rS1[k];
      m2 <= m2Next;
    end
    if (load[2]) begin
      yS3 <= yS2[0];
      for (int k = 0; k < T11; k++) rS3[k] <= rS2[k];
      m3   <= m3Next;
      s1S3 <= s1Next;
    end
    if (load[3]) begin
      m4   <= m4Next;
      s1S4 <= s1S3;
      s0S4 <= s0Next;
    end
  end
endmodule

// File: rtl/lfsd_llr.sv
module lfsd_llr
  import lfsd_pkg::*;
#(
  parameter int METRIC_W = 16,
  parameter int LLR_W    = 12
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          load,
  input  logic [NUM_PATHS*METRIC_W-1:0] pathMetric,
  input  logic [NUM_PATHS*NUM_BITS-1:0] pathSym,
  output logic [NUM_BITS*LLR_W-1:0]     llrOut
);
  localparam logic signed [LLR_W-1:0]    LLR_LIM  = {1'b0, {(LLR_W-1){1'b1}}};
  localparam logic signed [METRIC_W+1:0] DIFF_LIM = {{(METRIC_W+3-LLR_W){1'b0}}, {(LLR_W-1){1'b1}}};

  logic [NUM_BITS*LLR_W-1:0] llrNext;

  for (genvar b = 0; b < NUM_BITS; b++) begin : g_bit
    localparam int LAYER = b / SYM_BITS;
    localparam int POS   = b % SYM_BITS;
    logic [METRIC_W-1:0]      minZero, minOne, metric;
    logic                     haveZero, haveOne;
    symIdx_t                  label;
    logic signed [METRIC_W+1:0] diff;
    logic signed [LLR_W-1:0]  value;

    always_comb begin
      minZero  = '1;
      minOne   = '1;
      haveZero = 1'b0;
      haveOne  = 1'b0;
      label    = '0;
      metric   = '0;
      for (int p = 0; p < NUM_PATHS; p++) begin
        label  = grayOf(pathSym[p*NUM_BITS + LAYER*SYM_BITS +: SYM_BITS]);
        metric = pathMetric[p*METRIC_W +: METRIC_W];
        if (label[POS]) begin
          haveOne = 1'b1;
          if (metric < minOne) minOne = metric;
        end else begin
          haveZero = 1'b1;
          if (metric < minZero) minZero = metric;
        end
      end
      diff = $signed({2'b00, minOne}) - $signed({2'b00, minZero});
      if (!haveOne)              value = LLR_LIM;
      else if (!haveZero)        value = -LLR_LIM;
      else if (diff > DIFF_LIM)  value = LLR_LIM;
      else if (diff < -DIFF_LIM) value = -LLR_LIM;
      else                       value = diff[LLR_W-1:0];
    end

    assign llrNext[b*LLR_W +: LLR_W] = value;
  end

  always_ff @(posedge clk) begin
    if (rst)       llrOut <= '0;
    else if (load) llrOut <= llrNext;
  end
endmodule

// File: rtl/lfsd_detector.sv
module lfsd_detector
  import lfsd_pkg::*;
#(
  parameter int IN_W     = 10,
  parameter int METRIC_W = 16,
  parameter int LLR_W    = 12
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        inValid,
  input  logic [NUM_LAYERS*IN_W-1:0]  rxVec,
  input  logic [NUM_TRI*IN_W-1:0]     rMat,
  output logic                        outValid,
  output logic [NUM_BITS*LLR_W-1:0]   outLlr
);
  strobe_t                        strobe;
  logic [NUM_PATHS*METRIC_W-1:0]  pathMetric;
  logic [NUM_PATHS*NUM_BITS-1:0]  pathSym;

  lfsd_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  lfsd_tree #(.IN_W(IN_W), .METRIC_W(METRIC_W)) u_tree (
    .clk        (clk),
    .load       (strobe.treeLoad),
    .rxVec      (rxVec),
    .rMat       (rMat),
    .pathMetric (pathMetric),
    .pathSym    (pathSym)
  );

  lfsd_llr #(.METRIC_W(METRIC_W), .LLR_W(LLR_W)) u_llr (
    .clk        (clk),
    .rst        (rst),
    .load       (strobe.llrLoad),
    .pathMetric (pathMetric),
    .pathSym    (pathSym),
    .llrOut     (outLlr)
  );
endmodule

// File: rtl/lfsd_checker.sv
module lfsd_checker
  import lfsd_pkg::*;
#(
  parameter int LLR_W = 12
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      inValid,
  input logic                      outValid,
  input logic [NUM_BITS*LLR_W-1:0] outLlr
);
  logic [2:0] sinceReset;

  always_ff @(posedge clk) begin
    if (rst)                     sinceReset <= '0;
    else if (sinceReset != 3'd7) sinceReset <= sinceReset + 3'd1;
  end

  // R1
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    (sinceReset >= 3'd5) |-> (outValid == $past(inValid, 5)));

  // R3
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!outValid && outLlr == '0));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(outLlr));

  for (genvar b = 0; b < NUM_BITS; b++) begin : g_range
    // R7
    llr_range_chk: assert property (@(posedge clk) disable iff (rst)
      outValid |-> (outLlr[b*LLR_W +: LLR_W] != {1'b1, {(LLR_W-1){1'b0}}}));
  end
endmodule

bind lfsd_detector lfsd_checker #(.LLR_W(LLR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .outValid (outValid),
  .outLlr   (outLlr)
);

// File: tb/lfsd_detector_test.sv
module lfsd_detector_test;
  localparam int IW   = 10;
  localparam int LW   = 12;
  localparam int NB   = 8;
  localparam int MAXM = 65535;
  localparam int LMAX = 2047;
  localparam int NCYC = 800;
  localparam int NT   = NCYC + 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid;
  logic [4*IW-1:0]  rxVec;
  logic [10*IW-1:0] rMat;
  logic outValid;
  logic [NB*LW-1:0] outLlr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int curY [4];
  int curR [4][4];
  int txI  [4];

  bit               expV   [NT];
  logic [NB*LW-1:0] expL   [NT];
  string            expTag [NT];
  int               expTx  [NT][4];
  logic [NB*LW-1:0] lastLlr;

  always #10 clk = ~clk;

  lfsd_detector uut (
    .clk(clk), .rst(rst), .inValid(inValid), .rxVec(rxVec), .rMat(rMat),
    .outValid(outValid), .outLlr(outLlr)
  );

  function automatic int ampl(int i);
    return 2 * i - 3;
  endfunction

  function automatic int sqSat(int z);
    int s;
    s = z * z;
    return (s > MAXM) ? MAXM : s;
  endfunction

  function automatic int addSat(int a, int b);
    return (a + b > MAXM) ? MAXM : a + b;
  endfunction

  // R9: label of index 0..3 is 00, 01, 11, 10
  function automatic int grayLbl(int i);
    case (i)
      0: return 0;
      1: return 1;
      2: return 3;
      default: return 2;
    endcase
  endfunction

  function automatic int nearest(int z, int r);
    int best, bi, d;
    best = -1;
    bi = 0;
    for (int s = 0; s < 4; s++) begin
      d = (z - r * ampl(s)) * (z - r * ampl(s));
      if (best < 0 || d <= best) begin best = d; bi = s; end
    end
    return bi;
  endfunction

  function automatic logic [NB*LW-1:0] refLlr();
    int met [16];
    int sym [16][4];
    int z, m, i1, i0, k, pos, min0, min1, v, lbl;
    bit f0, f1;
    logic [NB*LW-1:0] res;
    for (int p = 0; p < 16; p++) begin
      sym[p][3] = p / 4;
      sym[p][2] = p % 4;
      z = curY[3] - curR[3][3] * ampl(sym[p][3]);
      m = sqSat(z);
      z = curY[2] - curR[2][3] * ampl(sym[p][3]) - curR[2][2] * ampl(sym[p][2]);
      m = addSat(m, sqSat(z));
      z = curY[1] - curR[1][2] * ampl(sym[p][2]) - curR[1][3] * ampl(sym[p][3]);
      i1 = nearest(z, curR[1][1]);
      m = addSat(m, sqSat(z - curR[1][1] * ampl(i1)));
      z = curY[0] - curR[0][1] * ampl(i1) - curR[0][2] * ampl(sym[p][2])
          - curR[0][3] * ampl(sym[p][3]);
      i0 = nearest(z, curR[0][0]);
      m = addSat(m, sqSat(z - curR[0][0] * ampl(i0)));
      sym[p][1] = i1;
      sym[p][0] = i0;
      met[p] = m;
    end
    res = '0;
    for (int b = 0; b < NB; b++) begin
      k = b / 2;
      pos = b % 2;
      min0 = MAXM + 1; min1 = MAXM + 1; f0 = 0; f1 = 0;
      for (int p = 0; p < 16; p++) begin
        lbl = (grayLbl(sym[p][k]) >> pos) & 1;
        if (lbl == 1) begin f1 = 1; if (met[p] < min1) min1 = met[p]; end
        else begin f0 = 1; if (met[p] < min0) min0 = met[p]; end
      end
      if (!f1) v = LMAX;
      else if (!f0) v = -LMAX;
      else begin
        v = min1 - min0;
        if (v > LMAX) v = LMAX;
        if (v < -LMAX) v = -LMAX;
      end
      res[b*LW +: LW] = v[LW-1:0];
    end
    return res;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [NB*LW-1:0] act, input logic [NB*LW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic clearR();
    for (int i = 0; i < 4; i++) for (int j = 0; j < 4; j++) curR[i][j] = 0;
  endtask

  task automatic randVec();
    clearR();
    for (int i = 0; i < 4; i++) begin
      curR[i][i] = int'($urandom_range(8, 60));
      for (int j = i + 1; j < 4; j++) curR[i][j] = int'($urandom_range(0, 80)) - 40;
      curY[i] = int'($urandom_range(0, 600)) - 300;
    end
  endtask

  task automatic driveVec(input bit v);
    int t;
    t = 0;
    for (int i = 0; i < 4; i++) begin
      rxVec[i*IW +: IW] = curY[i][IW-1:0];
      for (int j = i; j < 4; j++) begin
        rMat[t*IW +: IW] = curR[i][j][IW-1:0];
        t++;
      end
    end
    inValid = v;
  endtask

  task automatic scoreboard(input int idx);
    logic signed [LW-1:0] l;
    int bitv;
    check(outValid === expV[idx], (expV[idx] ? expTag[idx] : "R1"), "outValid",
          {{(NB*LW-1){1'b0}}, outValid}, {{(NB*LW-1){1'b0}}, expV[idx]});
    if (expV[idx]) begin
      check(outLlr === expL[idx], expTag[idx], "soft values", outLlr, expL[idx]);
      lastLlr = expL[idx];
      if (expTag[idx] == "R9") begin
        for (int b = 0; b < NB; b++) begin
          l = outLlr[b*LW +: LW];
          bitv = (grayLbl(expTx[idx][b/2]) >> (b % 2)) & 1;
          check(bitv == 1 ? (l < 0) : (l > 0), "R9", "sign of sent bit",
                outLlr, expL[idx]);
        end
      end
    end else begin
      check(outLlr === lastLlr, "R10", "hold in gap", outLlr, lastLlr);
    end
  endtask

  initial begin
    int unused;
    unused = $urandom(777);
    inValid = 1'b0;
    rxVec = '0;
    rMat = '0;
    lastLlr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0 && outLlr == '0, "R3", "reset state", outLlr, '0);
    for (int c = 0; c < NT + 5; c++) begin
      @(negedge clk);
      if (c >= 5) scoreboard(c - 5);
      if (c < NT) begin
        bit v;
        v = 1'b1;
        for (int i = 0; i < 4; i++) txI[i] = 0;
        if (c == 0) begin
          clearR();
          for (int i = 0; i < 4; i++) curR[i][i] = 20;
          curR[0][1] = 3; curR[0][2] = -4; curR[0][3] = 5;
          curR[1][2] = 2; curR[1][3] = -6; curR[2][3] = 7;
          txI[0] = 1; txI[1] = 3; txI[2] = 0; txI[3] = 2;
          for (int i = 0; i < 4; i++) begin
            curY[i] = 0;
            for (int j = i; j < 4; j++) curY[i] += curR[i][j] * ampl(txI[j]);
          end
          expTag[c] = "R9";
        end else if (c == 1) begin
          clearR();
          for (int i = 0; i < 4; i++) curR[i][i] = 4;
          curY[3] = 5; curY[2] = -7; curY[1] = 0; curY[0] = 8;
          expTag[c] = "R5";
        end else if (c == 2) begin
          for (int i = 0; i < 4; i++) for (int j = 0; j < 4; j++) curR[i][j] = (j >= i) ? 255 : 0;
          curY[3] = 511; curY[2] = -512; curY[1] = -512; curY[0] = -512;
          expTag[c] = "R6";
        end else if (c == 3) begin
          clearR();
          for (int i = 0; i < 4; i++) curR[i][i] = 50;
          curY[3] = 10; curY[2] = -20; curY[1] = 60; curY[0] = -90;
          expTag[c] = "R8";
        end else if (c == 4 || c >= NCYC) begin
          v = 1'b0;
          expTag[c] = "R1";
        end else if (c < 405) begin
          randVec();
          expTag[c] = (c % 3 == 0) ? "R2" : ((c % 3 == 1) ? "R4" : "R7");
        end else begin
          randVec();
          v = ($urandom_range(0, 1) == 1);
          expTag[c] = "R1";
        end
        for (int i = 0; i < 4; i++) expTx[c][i] = txI[i];
        expV[c] = v;
        expL[c] = v ? refLlr() : '0;
        driveVec(v);
      end
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule